// File: doc/BRIEF.md
# Peripheral Interrupt Status Register

This block keeps five sticky pending flags for a small processor that has one serial port and a bank of eight parallel data registers, together with a five-bit interrupt enable mask and a combined interrupt request. Hardware events set the flags: serial receive full, serial transmit empty, an external write into a parallel register, an external read from a parallel register, and an external interrupt pin. There is no write-to-clear path. Each flag clears as a side effect of the processor access that services it, or, for the pin flag, of a falling edge on the interrupt-acknowledge line.

A write to the mask lands in a holding register. The copy that gates the request follows it one cycle later, so an interrupt can still be taken in the cycle right after the mask is changed. While the parallel port is in passive mode, processor accesses to the parallel registers only clear flags and never start an external bus cycle.

Top module: `periph_irq_status`

## Requirements
- R1: After reset `statusOut`, `maskOut` and `irqOut` are all zero. The status bit positions are: bit 4 serial receive full, bit 3 serial transmit empty, bit 2 external parallel write, bit 1 external parallel read, bit 0 external interrupt pin.
- R2: A `serRxFull` strobe sets bit 4 at the next clock edge. A `cpuSerRd` strobe clears it.
- R3: A `serTxEmpty` strobe sets bit 3 at the next clock edge. A `cpuSerWr` strobe clears it.
- R4: An `extParWr` strobe sets bit 2 only while `passiveMode` is 1, and has no effect otherwise. A `cpuParRd` strobe clears bit 2.
- R5: An `extParRd` strobe sets bit 1 only while `passiveMode` is 1, and has no effect otherwise. A `cpuParWr` strobe clears bit 1.
- R6: `parBusRd` equals `cpuParRd` and `parBusWr` equals `cpuParWr` while `passiveMode` is 0. Both are 0 whenever `passiveMode` is 1.
- R7: A rising edge on `intPin` sets bit 0 at the third clock edge after the pin is sampled high, but only if the active mask bit 0 is 1 when that edge is detected.
- R8: Bit 0 clears only at the clock edge where `intAck` is sampled 0 after having been sampled 1 at the previous edge. No other input clears it.
- R9: `maskWr` loads `maskIn` into `maskOut` at the next edge. The active mask used for the request and for gating the pin flag takes that value one edge later.
- R10: `irqOut` is the OR over all five bits of the status ANDed with the active mask.
- R11: If a set event and a clear event for the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serRxFull | input | 1 | Serial receive buffer became full (strobe) |
| serTxEmpty | input | 1 | Serial transmit buffer became empty (strobe) |
| extParWr | input | 1 | External device wrote a parallel register (strobe) |
| extParRd | input | 1 | External device read a parallel register (strobe) |
| passiveMode | input | 1 | Parallel port is driven by the external device |
| intPin | input | 1 | Asynchronous external interrupt pin |
| intAck | input | 1 | Interrupt acknowledge from the core |
| cpuSerRd | input | 1 | Processor reads the serial data register |
| cpuSerWr | input | 1 | Processor writes the serial data register |
| cpuParRd | input | 1 | Processor reads any parallel data register |
| cpuParWr | input | 1 | Processor writes any parallel data register |
| maskWr | input | 1 | Write strobe for the enable mask |
| maskIn | input | 5 | New enable mask |
| statusOut | output | 5 | Pending flags |
| maskOut | output | 5 | Last written enable mask |
| irqOut | output | 1 | Combined interrupt request |
| parBusRd | output | 1 | Start an external parallel read cycle |
| parBusWr | output | 1 | Start an external parallel write cycle |

## Verification
A flag that is stuck, or a clear routed to the wrong bit, shows up on `statusOut` at the very next edge after the servicing access. A fault in the mask pipeline shows up as `irqOut` running one cycle early or late around a mask write. Errors in the synchronizer or in the edge detectors move the set time of the pin flag away from exactly three edges, or make the flag reappear while the pin is held high. A missing passive-mode gate shows up at once as a bus strobe or a spurious parallel flag.

// File: rtl/periph_irq_pkg.sv
package periph_irq_pkg;
  localparam int FLAG_W = 5;
  localparam int BIT_SRX = 4;
  localparam int BIT_STX = 3;
  localparam int BIT_PWR = 2;
  localparam int BIT_PRD = 1;
  localparam int BIT_INT = 0;

  typedef struct packed {
    logic [FLAG_W-1:0] setVec;
    logic [FLAG_W-1:0] clrVec;
  } flagStrobes_t;
endpackage

// File: rtl/periph_irq_ctl.sv
module periph_irq_ctl
  import periph_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serRxFull,
  input  logic serTxEmpty,
  input  logic extParWr,
  input  logic extParRd,
  input  logic passiveMode,
  input  logic intPin,
  input  logic intAck,
  input  logic cpuSerRd,
  input  logic cpuSerWr,
  input  logic cpuParRd,
  input  logic cpuParWr,
  input  logic intEnable,
  output flagStrobes_t strobes,
  output logic parBusRd,
  output logic parBusWr
);
  logic [SYNC_STAGES-1:0] pinSync;
  logic pinPrev;
  logic ackPrev;
  logic pinRise;
  logic ackFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinSync <= '0;
      pinPrev <= 1'b0;
      ackPrev <= 1'b0;
    end else begin
      pinSync <= {pinSync[SYNC_STAGES-2:0], intPin};
      pinPrev <= pinSync[SYNC_STAGES-1];
      ackPrev <= intAck;
    end
  end

  assign pinRise = pinSync[SYNC_STAGES-1] & ~pinPrev;
  assign ackFall = ackPrev & ~intAck;

  always_comb begin
    strobes = '0;
    strobes.setVec[BIT_SRX] = serRxFull;
    strobes.setVec[BIT_STX] = serTxEmpty;
    strobes.setVec[BIT_PWR] = extParWr & passiveMode;
    strobes.setVec[BIT_PRD] = extParRd & passiveMode;
    strobes.setVec[BIT_INT] = pinRise & intEnable;
    strobes.clrVec[BIT_SRX] = cpuSerRd;
    strobes.clrVec[BIT_STX] = cpuSerWr;
    strobes.clrVec[BIT_PWR] = cpuParRd;
    strobes.clrVec[BIT_PRD] = cpuParWr;
    strobes.clrVec[BIT_INT] = ackFall;
  end

  assign parBusRd = cpuParRd & ~passiveMode;
  assign parBusWr = cpuParWr & ~passiveMode;
endmodule

// File: rtl/periph_irq_dp.sv
module periph_irq_dp
  import periph_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  flagStrobes_t strobes,
  input  logic maskWr,
  input  logic [FLAG_W-1:0] maskIn,
  output logic [FLAG_W-1:0] statusOut,
  output logic [FLAG_W-1:0] maskOut,
  output logic intEnable,
  output logic irqOut
);
  logic [FLAG_W-1:0] flagReg;
  logic [FLAG_W-1:0] maskHold;
  logic [FLAG_W-1:0] maskActive;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagReg[i] <= 1'b0;
      else if (strobes.setVec[i]) flagReg[i] <= 1'b1;
      else if (strobes.clrVec[i]) flagReg[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskHold   <= '0;
      maskActive <= '0;
    end else begin
      maskActive <= maskHold;
      if (maskWr) maskHold <= maskIn;
    end
  end

  assign statusOut = flagReg;
  assign maskOut   = maskHold;
  assign intEnable = maskActive[BIT_INT];
  assign irqOut    = |(flagReg & maskActive);
endmodule

// File: rtl/periph_irq_status.sv
module periph_irq_status
  import periph_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic serRxFull,
  input  logic serTxEmpty,
  input  logic extParWr,
  input  logic extParRd,
  input  logic passiveMode,
  input  logic intPin,
  input  logic intAck,
  input  logic cpuSerRd,
  input  logic cpuSerWr,
  input  logic cpuParRd,
  input  logic cpuParWr,
  input  logic maskWr,
  input  logic [4:0] maskIn,
  output logic [4:0] statusOut,
  output logic [4:0] maskOut,
  output logic irqOut,
  output logic parBusRd,
  output logic parBusWr
);
  flagStrobes_t strobes;
  logic intEnable;

  periph_irq_ctl #(.SYNC_STAGES(2)) u_ctl (
    .clk(clk), .rstN(rstN),
    .serRxFull(serRxFull), .serTxEmpty(serTxEmpty),
    .extParWr(extParWr), .extParRd(extParRd),
    .passiveMode(passiveMode), .intPin(intPin), .intAck(intAck),
    .cpuSerRd(cpuSerRd), .cpuSerWr(cpuSerWr),
    .cpuParRd(cpuParRd), .cpuParWr(cpuParWr),
    .intEnable(intEnable), .strobes(strobes),
    .parBusRd(parBusRd), .parBusWr(parBusWr)
  );

  periph_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .maskWr(maskWr), .maskIn(maskIn),
    .statusOut(statusOut), .maskOut(maskOut),
    .intEnable(intEnable), .irqOut(irqOut)
  );
endmodule

// File: rtl/periph_irq_status_chk.sv
module periph_irq_status_chk (
  input logic clk,
  input logic rstN,
  input logic serRxFull,
  input logic serTxEmpty,
  input logic extParWr,
  input logic extParRd,
  input logic passiveMode,
  input logic intPin,
  input logic intAck,
  input logic cpuSerRd,
  input logic cpuSerWr,
  input logic cpuParRd,
  input logic cpuParWr,
  input logic maskWr,
  input logic [4:0] maskIn,
  input logic [4:0] statusOut,
  input logic [4:0] maskOut,
  input logic irqOut,
  input logic parBusRd,
  input logic parBusWr
);
  // R6
  passive_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    passiveMode |-> (!parBusRd && !parBusWr));
  // R2
  srx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSerRd && !serRxFull) |=> !statusOut[4]);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serRxFull && cpuSerRd) |=> statusOut[4]);
  // R4
  pwr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!passiveMode && !statusOut[2]) |=> !statusOut[2]);
  // R8
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[0] && !($past(intAck) && !intAck)) |=> statusOut[0]);
  // R10
  irq_combine_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(statusOut & $past(maskOut)));
  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskWr |=> (maskOut == $past(maskIn)));
endmodule

bind periph_irq_status periph_irq_status_chk u_chk (.*);

// File: tb/periph_irq_status_test.sv
`timescale 1ns/1ps
module periph_irq_status_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serRxFull = 0, serTxEmpty = 0, extParWr = 0, extParRd = 0;
  logic passiveMode = 0, intPin = 0, intAck = 0;
  logic cpuSerRd = 0, cpuSerWr = 0, cpuParRd = 0, cpuParWr = 0;
  logic maskWr = 0;
  logic [4:0] maskIn = '0;
  logic [4:0] statusOut, maskOut;
  logic irqOut, parBusRd, parBusWr;

  int total = 0;
  int bad = 0;
  logic [4:0] mStat = '0, mMask = '0, mAct = '0;
  logic p1 = 0, p2 = 0, p3 = 0, pAck = 0;

  always #10 clk = ~clk;

  periph_irq_status uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] nextStat(input logic [4:0] s);
    logic [4:0] setV, clrV;
    setV = {serRxFull, serTxEmpty, extParWr & passiveMode, extParRd & passiveMode,
            p2 & ~p3 & mAct[0]};
    clrV = {cpuSerRd, cpuSerWr, cpuParRd, cpuParWr, pAck & ~intAck};
    return (s & ~clrV) | setV;
  endfunction

  // inputs are already driven; check bus strobes, clock once, check state
  task automatic step();
    #1;
    chk(parBusRd == (cpuParRd & ~passiveMode), "R6 parBusRd", parBusRd, cpuParRd & ~passiveMode);
    chk(parBusWr == (cpuParWr & ~passiveMode), "R6 parBusWr", parBusWr, cpuParWr & ~passiveMode);
    mStat = nextStat(mStat);
    mAct = mMask;
    if (maskWr) mMask = maskIn;
    p3 = p2; p2 = p1; p1 = intPin; pAck = intAck;
    @(posedge clk);
    @(negedge clk);
    chk(statusOut == mStat, "R2-R5,R7,R8,R11 status", statusOut, mStat);
    chk(maskOut == mMask, "R9 maskOut", maskOut, mMask);
    chk(irqOut == |(mStat & mAct), "R10 irqOut", irqOut, |(mStat & mAct));
  endtask

  task automatic idle();
    {serRxFull, serTxEmpty, extParWr, extParRd, cpuSerRd, cpuSerWr,
     cpuParRd, cpuParWr, maskWr} = '0;
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(statusOut == 5'h0 && maskOut == 5'h0 && irqOut == 1'b0, "R1 reset",
        {statusOut, maskOut, irqOut}, 0);

    // R11 set and clear together on serial receive flag
    serRxFull = 1; cpuSerRd = 1; step(); idle();
    chk(statusOut[4] == 1'b1, "R11 set wins", statusOut[4], 1);
    // R2 read clears
    cpuSerRd = 1; step(); idle();
    chk(statusOut[4] == 1'b0, "R2 clear", statusOut[4], 0);
    // R3 set then clear
    serTxEmpty = 1; step(); idle();
    chk(statusOut[3] == 1'b1, "R3 set", statusOut[3], 1);
    cpuSerWr = 1; step(); idle();
    chk(statusOut[3] == 1'b0, "R3 clear", statusOut[3], 0);
    // R4 R5 ignored outside passive mode
    passiveMode = 0; extParWr = 1; extParRd = 1; step(); idle();
    chk(statusOut[2:1] == 2'b00, "R4 R5 active mode ignore", statusOut[2:1], 0);
    passiveMode = 1; extParWr = 1; extParRd = 1; step(); idle();
    chk(statusOut[2:1] == 2'b11, "R4 R5 passive set", statusOut[2:1], 3);
    cpuParRd = 1; step(); idle();
    chk(statusOut[2:1] == 2'b01, "R4 clear by read", statusOut[2:1], 1);
    cpuParWr = 1; step(); idle();
    chk(statusOut[2:1] == 2'b00, "R5 clear by write", statusOut[2:1], 0);

    // R9 mask delay, R10 request
    serRxFull = 1; step(); idle();
    maskWr = 1; maskIn = 5'h10; step(); idle();
    chk(irqOut == 1'b0, "R9 mask not yet active", irqOut, 0);
    step();
    chk(irqOut == 1'b1, "R10 irq after delay", irqOut, 1);
    cpuSerRd = 1; step(); idle();

    // R7 pin flag with enable bit 0 active
    maskWr = 1; maskIn = 5'h01; step(); idle(); step();
    intPin = 1; step(); step();
    chk(statusOut[0] == 1'b0, "R7 not yet set", statusOut[0], 0);
    step();
    chk(statusOut[0] == 1'b1, "R7 set after three edges", statusOut[0], 1);
    // R8 other accesses do not clear
    cpuSerRd = 1; cpuSerWr = 1; cpuParRd = 1; cpuParWr = 1; step(); idle();
    chk(statusOut[0] == 1'b1, "R8 not cleared by accesses", statusOut[0], 1);
    intAck = 1; step();
    chk(statusOut[0] == 1'b1, "R8 ack high keeps", statusOut[0], 1);
    intAck = 0; step();
    chk(statusOut[0] == 1'b0, "R8 ack fall clears", statusOut[0], 0);
    repeat (4) step();
    chk(statusOut[0] == 1'b0, "R7 held pin does not reset flag", statusOut[0], 0);
    // R7 masked
    intPin = 0; maskWr = 1; maskIn = 5'h00; step(); idle(); step(); step();
    intPin = 1; repeat (5) step();
    chk(statusOut[0] == 1'b0, "R7 masked pin ignored", statusOut[0], 0);
    intPin = 0; step(); step();

    // random mix against model
    for (int i = 0; i < 2000; i++) begin
      serRxFull   = ($urandom % 4) == 0;
      serTxEmpty  = ($urandom % 4) == 0;
      extParWr    = ($urandom % 4) == 0;
      extParRd    = ($urandom % 4) == 0;
      passiveMode = $urandom % 2;
      intPin      = ($urandom % 8) < 3;
      intAck      = $urandom % 2;
      cpuSerRd    = ($urandom % 3) == 0;
      cpuSerWr    = ($urandom % 3) == 0;
      cpuParRd    = ($urandom % 3) == 0;
      cpuParWr    = ($urandom % 3) == 0;
      maskWr      = ($urandom % 6) == 0;
      maskIn      = 5'($urandom);
      step();
    end
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule